// File: doc/BRIEF.md
# Slew-Limited Reference Code Selector

This block produces the digital reference code that a voltage control loop regulates against. Four reference levels are held in registers that take their values from four externally strapped defaults while reset is asserted. In the normal (parallel) mode a 2-bit select input chooses one of the four levels as the target. A simple write-strobe register port, standing in for a bus protocol engine, can overwrite any of the levels. It can also switch the block into a serial mode, where a 6-bit table code written over the port sets the target directly as a fixed offset plus the code.

The output code never jumps to a new target. When a slew tick arrives, it moves one LSB toward the target, the same pacing the soft-start ramp uses, and stops exactly on it. Until the startup sequencer raises its run input, the output follows the soft-start ramp code and target changes are not acted upon. A one-cycle pulse marks each change of target while running, and a settled flag shows when the output has reached the target.

Top module: `vref_select_slew`

## Requirements
- R1: While reset is low, the four level registers load from `dflt_levels` (level k at bits [8k+7:8k], k = 0..3), the mode returns to parallel, and `ref_code` clears to 0. Values written before a reset are not retained.
- R2: In parallel mode the target is the level selected by `vid_sel`: 00 picks level 1 (k=0), 01 level 2, 10 level 3, 11 level 4.
- R3: A cycle with `reg_wr` high and `reg_addr` 0..3 writes `reg_wdata` into level `reg_addr`+1 at that clock edge. Writes to addresses 6 and 7 change nothing.
- R4: A write to address 4 sets serial mode when `reg_wdata` bit 0 is 1 and returns to parallel mode when it is 0. `svid_active` shows the mode.
- R5: A write to address 5 stores `reg_wdata[5:0]` as the serial code. In serial mode the target is SVID_BASE (default 128) plus that code, and `vid_sel` has no effect.
- R6: While `run` is low, `ref_code` takes the value `ramp_code` had at the previous clock edge, and `ref_changed` stays low.
- R7: While `run` is high, `ref_code` changes only at an edge where `slew_tick` is high, and then by exactly one LSB toward the target.
- R8: `ref_code` stops exactly on the target and never passes it. A move of N codes takes N ticks.
- R9: While `run` is high, `ref_changed` is high for the one cycle that follows a change of target, and it is low otherwise.
- R10: `ref_settled` is high exactly when `run` is high and `ref_code` equals the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the default levels |
| dflt_levels | input | 32 | Four strapped default levels, level 1 in the low byte |
| vid_sel | input | 2 | Parallel level select |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0..3 levels, 4 mode, 5 serial code |
| reg_wdata | input | 8 | Register write data |
| run | input | 1 | Startup sequencer has finished soft start |
| ramp_code | input | 8 | Soft-start ramp code, followed while run is low |
| slew_tick | input | 1 | One-cycle slew pacing pulse |
| ref_code | output | 8 | Reference code for the control loop |
| ref_changed | output | 1 | One-cycle pulse on a change of target while running |
| ref_settled | output | 1 | Output equals target while running |
| svid_active | output | 1 | Serial mode is selected |

## Verification
The bench drives moves in both directions and of different lengths. It counts the ticks each one needs, so a design that overshoots, moves two codes per tick or stops one code short is caught. It rewrites the selected level while it is in use and sends writes to unused addresses. It toggles the select input in serial mode and before run, where a design that still follows the input would move the output or pulse the change flag. A final reset shows whether overwritten levels wrongly survive, and a pause of the tick shows whether the output drifts without pacing.

// File: rtl/vref_pkg.sv
package vref_pkg;
  localparam int NLEVEL = 4;
  localparam int SEL_W  = $clog2(NLEVEL);
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SCODE = 3'd5;
endpackage

// File: rtl/vref_level_bank.sv
module vref_level_bank
  import vref_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int SVID_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NLEVEL*CODE_W-1:0]   dflt_levels,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [CODE_W-1:0]          reg_wdata,
  output logic [NLEVEL*CODE_W-1:0]   levels,
  output logic                       svid_en,
  output logic [SVID_W-1:0]          svid_code
);
  // One register per level, each with its own write decode.
  for (genvar k = 0; k < NLEVEL; k++) begin : g_lvl
    logic hit;
    assign hit = reg_wr && (reg_addr == ADDR_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)   levels[k*CODE_W +: CODE_W] <= dflt_levels[k*CODE_W +: CODE_W];
      else if (hit) levels[k*CODE_W +: CODE_W] <= reg_wdata;
    end
  end

  logic mode_hit, code_hit;
  assign mode_hit = reg_wr && (reg_addr == ADDR_MODE);
  assign code_hit = reg_wr && (reg_addr == ADDR_SCODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svid_en   <= 1'b0;
      svid_code <= '0;
    end else begin
      if (mode_hit) svid_en   <= reg_wdata[0];
      if (code_hit) svid_code <= reg_wdata[SVID_W-1:0];
    end
  end
endmodule

// File: rtl/vref_target_sel.sv
module vref_target_sel
  import vref_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int SVID_W    = 6,
  parameter int SVID_BASE = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [NLEVEL*CODE_W-1:0] levels,
  input  logic [SEL_W-1:0]         vid_sel,
  input  logic                     svid_en,
  input  logic [SVID_W-1:0]        svid_code,
  output logic [CODE_W-1:0]        tgt_code,
  output logic                     tgt_moved
);
  function automatic logic [CODE_W-1:0] svid_to_code(input logic [SVID_W-1:0] c);
    return CODE_W'(SVID_BASE) + CODE_W'(c);
  endfunction

  logic [CODE_W-1:0] par_code;
  logic [CODE_W-1:0] tgt_prev;

  assign par_code = levels[vid_sel*CODE_W +: CODE_W];
  assign tgt_code = svid_en ? svid_to_code(svid_code) : par_code;

  always_ff @(posedge clk) begin
    if (!rst_n) tgt_prev <= '0;
    else        tgt_prev <= tgt_code;
  end

  assign tgt_moved = run && (tgt_code != tgt_prev);
endmodule

// File: rtl/vref_slew.sv
module vref_slew #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              slew_tick,
  input  logic [CODE_W-1:0] ramp_code,
  input  logic [CODE_W-1:0] tgt_code,
  output logic [CODE_W-1:0] ref_code,
  output logic              at_target
);
  function automatic logic [CODE_W-1:0] step_toward(input logic [CODE_W-1:0] cur,
                                                    input logic [CODE_W-1:0] tgt);
    if (cur < tgt)      return cur + 1'b1;
    else if (cur > tgt) return cur - 1'b1;
    else                return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         ref_code <= '0;
    else if (!run)      ref_code <= ramp_code;
    else if (slew_tick) ref_code <= step_toward(ref_code, tgt_code);
  end

  assign at_target = run && (ref_code == tgt_code);
endmodule

// File: rtl/vref_select_slew.sv
module vref_select_slew
  import vref_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int SVID_W    = 6,
  parameter int SVID_BASE = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLEVEL*CODE_W-1:0] dflt_levels,
  input  logic [SEL_W-1:0]         vid_sel,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [CODE_W-1:0]        reg_wdata,
  input  logic                     run,
  input  logic [CODE_W-1:0]        ramp_code,
  input  logic                     slew_tick,
  output logic [CODE_W-1:0]        ref_code,
  output logic                     ref_changed,
  output logic                     ref_settled,
  output logic                     svid_active
);
  logic [NLEVEL*CODE_W-1:0] levels;
  logic                     svid_en;
  logic [SVID_W-1:0]        svid_code;
  logic [CODE_W-1:0]        tgt_code;

  vref_level_bank #(.CODE_W(CODE_W), .SVID_W(SVID_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .dflt_levels(dflt_levels),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .levels(levels), .svid_en(svid_en), .svid_code(svid_code)
  );

  vref_target_sel #(.CODE_W(CODE_W), .SVID_W(SVID_W), .SVID_BASE(SVID_BASE)) u_tsel (
    .clk(clk), .rst_n(rst_n), .run(run), .levels(levels), .vid_sel(vid_sel),
    .svid_en(svid_en), .svid_code(svid_code),
    .tgt_code(tgt_code), .tgt_moved(ref_changed)
  );

  vref_slew #(.CODE_W(CODE_W)) u_slew (
    .clk(clk), .rst_n(rst_n), .run(run), .slew_tick(slew_tick),
    .ramp_code(ramp_code), .tgt_code(tgt_code),
    .ref_code(ref_code), .at_target(ref_settled)
  );

  assign svid_active = svid_en;
endmodule

// File: rtl/vref_select_slew_chk.sv
module vref_select_slew_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              slew_tick,
  input logic [CODE_W-1:0] ramp_code,
  input logic [CODE_W-1:0] tgt_code,
  input logic [CODE_W-1:0] ref_code,
  input logic              ref_changed
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R6: ramp followed while not running
  p_track_ramp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(run) |-> ref_code == $past(ramp_code));

  // R6: no change pulse before run
  p_quiet_prerun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !ref_changed);

  // R7: no movement without a tick
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(run) && !$past(slew_tick) |-> $stable(ref_code));

  // R7: at most one LSB per edge
  p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(run) |->
      (ref_code == $past(ref_code)) ||
      (ref_code == CODE_W'($past(ref_code) + 1'b1)) ||
      (CODE_W'(ref_code + 1'b1) == $past(ref_code)));

  // R8: stays put once on target
  p_no_overshoot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(run) && ($past(ref_code) == $past(tgt_code)) |-> $stable(ref_code));
endmodule

bind vref_select_slew vref_select_slew_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .slew_tick(slew_tick),
  .ramp_code(ramp_code), .tgt_code(tgt_code), .ref_code(ref_code),
  .ref_changed(ref_changed)
);

// File: tb/vref_select_slew_test.sv
module vref_select_slew_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] dflt_levels;
  logic [1:0]  vid_sel;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic        run;
  logic [7:0]  ramp_code;
  logic        slew_tick;
  logic [7:0]  ref_code;
  logic        ref_changed, ref_settled, svid_active;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vref_select_slew uut (
    .clk(clk), .rst_n(rst_n), .dflt_levels(dflt_levels), .vid_sel(vid_sel),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .run(run),
    .ramp_code(ramp_code), .slew_tick(slew_tick), .ref_code(ref_code),
    .ref_changed(ref_changed), .ref_settled(ref_settled), .svid_active(svid_active)
  );

  // {vid_sel, expected code, expected tick count}, walked from code 110
  localparam logic [17:0] VEC [4] = '{
    {2'b00, 8'd100, 8'd10},
    {2'b11, 8'd120, 8'd20},
    {2'b10, 8'd90,  8'd30},
    {2'b01, 8'd110, 8'd20}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  // Count negedges until settled; every step must be one LSB and never pass exp.
  task automatic slew_to(input logic [7:0] exp, input int steps, input string tag);
    int n = 0;
    logic bad = 1'b0;
    logic [7:0] prev = ref_code;
    while (!ref_settled && n < 400) begin
      @(negedge clk); #1;
      n++;
      if (ref_code != prev && ref_code != prev + 8'd1 && ref_code + 8'd1 != prev) bad = 1'b1;
      if ((prev < exp && ref_code > exp) || (prev > exp && ref_code < exp)) bad = 1'b1;
      prev = ref_code;
    end
    check(ref_code == exp, {tag, " R8 final code"}, ref_code, exp);
    check(n == steps, {tag, " R8 tick count"}, n, steps);
    check(!bad, {tag, " R7 single-LSB steps"}, bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; ramp_code = 8'd37; slew_tick = 1'b0;
    dflt_levels = {8'd120, 8'd90, 8'd110, 8'd100};
    vid_sel = 2'b01; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    #1; check(ref_code == 8'd0, "R1 reset code", ref_code, 0);
    check(svid_active == 1'b0, "R1 parallel mode at reset", svid_active, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(ref_code == 8'd37, "R6 follows ramp", ref_code, 37);
    check(!ref_changed, "R6 no pulse before run", ref_changed, 0);
    check(!ref_settled, "R10 not settled before run", ref_settled, 0);

    // R6: select changes are ignored before run
    vid_sel = 2'b00; #1;
    check(!ref_changed, "R6 select change before run", ref_changed, 0);
    ramp_code = 8'd110;
    @(negedge clk); #1;
    check(ref_code == 8'd110, "R6 follows ramp update", ref_code, 110);
    vid_sel = 2'b01;

    @(negedge clk); run = 1'b1; slew_tick = 1'b1; #1;
    check(ref_settled, "R10 settled on level 2 at run", ref_settled, 1);
    check(!ref_changed, "R9 no pulse at run entry", ref_changed, 0);

    // R2 vector walk
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      vid_sel = VEC[i][17:16]; #1;
      check(ref_changed, "R9 pulse on select change", ref_changed, 1);
      check(!ref_settled, "R10 not settled after change", ref_settled, 0);
      @(negedge clk); #1;
      check(!ref_changed, "R9 pulse lasts one cycle", ref_changed, 0);
      slew_to(VEC[i][15:8], int'(VEC[i][7:0]) - 1, "R2 level select");
    end

    // R7: no tick, no motion
    @(negedge clk); slew_tick = 1'b0; vid_sel = 2'b00;
    repeat (5) @(negedge clk);
    #1;
    check(ref_code == 8'd110, "R7 held without tick", ref_code, 110);
    check(!ref_settled, "R10 unsettled while target differs", ref_settled, 0);
    slew_tick = 1'b1;
    slew_to(8'd100, 10, "R7 resume ticks");

    // R3: overwrite selected level, then ignored addresses
    @(negedge clk); vid_sel = 2'b10; #1;
    slew_to(8'd90, 10, "R2 level 3");
    @(negedge clk); reg_write(3'd2, 8'd95);
    check(ref_changed, "R3 write to active level pulses", ref_changed, 1);
    slew_to(8'd95, 5, "R3 overwritten level");
    @(negedge clk); reg_write(3'd6, 8'd200);
    check(!ref_changed, "R3 unused address no pulse", ref_changed, 0);
    reg_write(3'd7, 8'd1);
    repeat (3) @(negedge clk);
    #1;
    check(ref_code == 8'd95 && ref_settled, "R3 unused address no effect", ref_code, 95);

    // R4/R5: serial mode
    reg_write(3'd5, 8'd3);
    check(!ref_changed, "R5 code write in parallel mode", ref_changed, 0);
    reg_write(3'd4, 8'd1);
    check(svid_active, "R4 serial mode on", svid_active, 1);
    check(ref_changed, "R4 mode switch pulses", ref_changed, 1);
    slew_to(8'd131, 36, "R5 serial target");
    @(negedge clk); vid_sel = 2'b00; #1;
    check(!ref_changed, "R5 select ignored in serial", ref_changed, 0);
    repeat (3) @(negedge clk);
    #1;
    check(ref_code == 8'd131, "R5 code unchanged by select", ref_code, 131);
    reg_write(3'd4, 8'd0);
    check(!svid_active, "R4 back to parallel", svid_active, 0);
    slew_to(8'd100, 31, "R4 parallel level 1");

    // R1: reset restores defaults
    @(negedge clk); rst_n = 1'b0; run = 1'b0; ramp_code = 8'd90;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; vid_sel = 2'b10;
    @(negedge clk); #1;
    check(ref_code == 8'd90, "R6 ramp after reset", ref_code, 90);
    run = 1'b1; #1;
    check(ref_settled, "R1 level 3 default restored", ref_settled, 1);
    repeat (3) @(negedge clk);
    #1;
    check(ref_code == 8'd90, "R1 level 3 stays default", ref_code, 90);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule